// File: doc/BRIEF.md
# Interleaved Memory Decoder Port Selector

This block holds the programming of a single host-managed device-memory decoder and uses it to map a host physical address onto an 8-bit downstream port number. Software-side logic writes three 32-bit registers through a simple write port: a control register and two target-list words. The control register carries an interleave-granularity code, an interleave-ways code and a committed flag. The two target-list words hold eight byte-wide port numbers.

A lookup request presents an address. The block divides the address by the decoded granularity, which is 256 bytes shifted left by the granularity code. It then keeps the quotient modulo two raised to the ways code, and uses the result to pick one byte of the target list. The answer arrives one cycle later as a response strobe, a hit flag and the port number. Lookups miss when the decoder is not committed or when the ways code is out of range.

The response path is a small state machine with three states. RSP_IDLE means no response this cycle. RSP_HIT means a valid response that hit, and RSP_MISS means a valid response that missed. Every cycle the state moves to RSP_HIT or RSP_MISS when a request is present, according to the lookup outcome, and to RSP_IDLE when no request is present.

Top module: `hdm_target_sel`

## Requirements
- R1: After reset, rsp_valid and rsp_hit are 0 and rsp_port is 0. All registers are cleared, so a lookup made right after reset misses.
- R2: rsp_valid is 1 in exactly the cycle that follows a cycle with lk_req high, and 0 otherwise.
- R3: When control bit 10 (committed) is 0, every lookup responds with rsp_hit=0.
- R4: wr_sel selects the register written when wr_en is high: 0 = control, 1 = target-list low word, 2 = target-list high word. In the control register, bits 3:0 are the granularity code and bits 7:4 are the ways code.
- R5: The selected index is (lk_addr >> (8 + granularity code)) modulo 2^(ways code).
- R6: Index i in 0..3 returns byte i of the low word (bits 8i+7:8i). Index i in 4..7 returns byte i-4 of the high word.
- R7: A ways code greater than 3 makes every lookup miss.
- R8: A lookup in the same cycle as a register write uses the register values from before that write.
- R9: rsp_port is 0 whenever rsp_hit is 0.
- R10: A write with wr_sel=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | REG_W | Write data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Host physical address to resolve |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup resolved to a port |
| rsp_port | output | PORT_W | Selected downstream port number |

## Verification
The assertions check on every cycle the properties that hold at the ports. These are the one-cycle response timing, the absence of stray responses, a zero port on a miss, and a miss whenever the decoder is uncommitted or its ways code is out of range. The correctness of the port number itself can only be shown by the bench. It sweeps granularity codes and every ways code, including the out-of-range ones, over addresses that aim at each target index, with extra bits set above the index field, and compares against arithmetic expectations. It also covers write-versus-lookup ordering, the unused register select, and the commit and uncommit sequence.

// File: rtl/hdm_sel_pkg.sv
package hdm_sel_pkg;
    // Control register field positions (decoded by the lookup path)
    localparam int IG_LSB          = 0;
    localparam int IW_LSB          = 4;
    localparam int COMMIT_BIT      = 10;
    // Granularity code 0 means 256-byte interleave
    localparam int GRAN_SHIFT_BASE = 8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TLO  = 2'd1,
        SEL_THI  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/hdm_regfile.sv
module hdm_regfile
    import hdm_sel_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int IG_W  = 4,
    parameter int IW_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [IG_W-1:0]  ig_enc,
    output logic [IW_W-1:0]  iw_enc,
    output logic             committed,
    output logic [REG_W-1:0] tgt_lo,
    output logic [REG_W-1:0] tgt_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ig_enc    <= '0;
            iw_enc    <= '0;
            committed <= 1'b0;
            tgt_lo    <= '0;
            tgt_hi    <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    ig_enc    <= wr_data[IG_LSB +: IG_W];
                    iw_enc    <= wr_data[IW_LSB +: IW_W];
                    committed <= wr_data[COMMIT_BIT];
                end
                SEL_TLO:  tgt_lo <= wr_data;
                SEL_THI:  tgt_hi <= wr_data;
                SEL_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/hdm_index_calc.sv
module hdm_index_calc
    import hdm_sel_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int REG_W  = 32,
    parameter int PORT_W = 8,
    parameter int IG_W   = 4,
    parameter int IW_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IG_W-1:0]   ig_enc,
    input  logic [IW_W-1:0]   iw_enc,
    input  logic              committed,
    input  logic [REG_W-1:0]  tgt_lo,
    input  logic [REG_W-1:0]  tgt_hi,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam int PER_WORD = REG_W / PORT_W;
    localparam int NUM_ENT  = 2 * PER_WORD;
    localparam int IDX_W    = $clog2(NUM_ENT);

    logic [PORT_W-1:0] entries [NUM_ENT];
    logic [ADDR_W-1:0] shifted;
    logic [IDX_W-1:0]  mask;
    logic [IDX_W-1:0]  idx;
    logic              ways_ok;

    // Lay the two target words out as one entry array
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        if (e < PER_WORD) begin : g_lo
            assign entries[e] = tgt_lo[e*PORT_W +: PORT_W];
        end else begin : g_hi
            assign entries[e] = tgt_hi[(e-PER_WORD)*PORT_W +: PORT_W];
        end
    end

    always_comb begin
        shifted = addr >> (GRAN_SHIFT_BASE + int'(ig_enc));
        for (int b = 0; b < IDX_W; b++) begin
            mask[b] = (IW_W'(b) < iw_enc);
        end
        idx     = shifted[IDX_W-1:0] & mask;
        ways_ok = (iw_enc <= IW_W'(IDX_W));
        hit     = committed && ways_ok;
        port    = hit ? entries[idx] : '0;
    end
endmodule

// File: rtl/hdm_target_sel.sv
module hdm_target_sel
    import hdm_sel_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int REG_W  = 32,
    parameter int PORT_W = 8,
    parameter int IG_W   = 4,
    parameter int IW_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_port
);
    logic [IG_W-1:0]   ig_enc;
    logic [IW_W-1:0]   ways_enc;
    logic              committed;
    logic [REG_W-1:0]  tgt_lo;
    logic [REG_W-1:0]  tgt_hi;
    logic              sel_hit;
    logic [PORT_W-1:0] sel_port;
    logic [PORT_W-1:0] port_q;

    rsp_state_e state_q, state_d;

    hdm_regfile #(.REG_W(REG_W), .IG_W(IG_W), .IW_W(IW_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ig_enc    (ig_enc),
        .iw_enc    (ways_enc),
        .committed (committed),
        .tgt_lo    (tgt_lo),
        .tgt_hi    (tgt_hi)
    );

    hdm_index_calc #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .PORT_W(PORT_W),
        .IG_W(IG_W), .IW_W(IW_W)
    ) u_idx (
        .addr      (lk_addr),
        .ig_enc    (ig_enc),
        .iw_enc    (ways_enc),
        .committed (committed),
        .tgt_lo    (tgt_lo),
        .tgt_hi    (tgt_hi),
        .hit       (sel_hit),
        .port      (sel_port)
    );

    // Next-state: a request lands in HIT or MISS, otherwise IDLE
    always_comb begin
        state_d = RSP_IDLE;
        if (lk_req) begin
            state_d = sel_hit ? RSP_HIT : RSP_MISS;
        end
    end

    // State register and captured port number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            port_q  <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= (lk_req && sel_hit) ? sel_port : '0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
            RSP_HIT:  begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            RSP_MISS: begin rsp_valid = 1'b1; rsp_hit = 1'b0; end
            default:  begin rsp_valid = 1'b0; rsp_hit = 1'b0; end
        endcase
        rsp_port = rsp_hit ? port_q : '0;
    end
endmodule

// File: rtl/hdm_target_sel_chk.sv
module hdm_target_sel_chk #(
    parameter int PORT_W = 8,
    parameter int IW_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic              committed,
    input logic [IW_W-1:0]   ways_enc,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PORT_W-1:0] rsp_port
);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    a_r2_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    a_r3_uncommitted_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !committed) |=> !rsp_hit);
    a_r7_bad_ways_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && (ways_enc > IW_W'(3))) |=> !rsp_hit);
    a_r9_miss_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_port == '0));
    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
endmodule

bind hdm_target_sel hdm_target_sel_chk #(.PORT_W(PORT_W), .IW_W(IW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .committed (committed),
    .ways_enc  (ways_enc),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_port  (rsp_port)
);

// File: tb/hdm_target_sel_bench.sv
`timescale 1ns/1ps
module hdm_target_sel_bench;
    localparam int ADDR_W = 48;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [31:0]       wr_data = '0;
    logic              lk_req = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rsp_valid, rsp_hit;
    logic [7:0]        rsp_port;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    // Bench shadow of programmed values
    logic [3:0]  m_ig = '0;
    logic [3:0]  m_iw = '0;
    logic        m_com = 1'b0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_hi = '0;

    always #5 clk = ~clk;

    hdm_target_sel u_hdm_target_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: begin m_ig = d[3:0]; m_iw = d[7:4]; m_com = d[10]; end
            2'd1: m_lo = d;
            2'd2: m_hi = d;
            default: ;
        endcase
    endtask

    function automatic logic [8:0] expect_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] q;
        int idx;
        if (!m_com || m_iw > 4'd3) return 9'd0;
        q   = a >> (8 + int'(m_ig));
        idx = int'(q % (48'd1 << m_iw));
        if (idx < 4) return {1'b1, m_lo[8*idx +: 8]};
        return {1'b1, m_hi[8*(idx-4) +: 8]};
    endfunction

    task automatic lookup(input logic [ADDR_W-1:0] a, input string req);
        logic [8:0] e;
        e = expect_of(a);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        check({req, " valid R2"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " hit"}, {31'd0, rsp_hit}, {31'd0, e[8]});
        check({req, " port"}, {24'd0, rsp_port}, {24'd0, e[7:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 hit", {31'd0, rsp_hit}, 32'd0);
        check("R1 port", {24'd0, rsp_port}, 32'd0);
        rst_n = 1'b1;
        lookup(48'h1234, "R1 post-reset lookup");
        @(negedge clk);
        check("R2 idle after response", {31'd0, rsp_valid}, 32'd0);

        wr(2'd1, 32'h1312_1110);
        wr(2'd2, 32'hC7C6_C5C4);

        // R3: uncommitted, valid fields
        wr(2'd0, 32'h0000_0031);
        for (int k = 0; k < 8; k++) lookup(48'(k) << 8, "R3 uncommitted");

        // R4 R5 R6 R7 R9: sweep granularity and ways codes
        for (int ig = 0; ig < 4; ig++) begin
            for (int iw = 0; iw < 6; iw++) begin
                wr(2'd0, 32'h400 | (32'(iw) << 4) | 32'(ig));
                for (int k = 0; k < 8; k++) begin
                    lookup((48'(k) << (8 + ig)) | 48'(k * 5 + 3) |
                           (48'(ig * 3 + iw + 1) << 30), "R5 R6 R7 sweep");
                end
            end
        end

        // Large granularity code
        wr(2'd0, 32'h0000_0439);
        for (int k = 0; k < 8; k++) lookup((48'(k) << 17) | 48'h1_FFFF, "R5 ig9");

        // R10: unused select leaves everything unchanged
        wr(2'd0, 32'h0000_0430);
        wr(2'd3, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) lookup(48'(k) << 8, "R10 sel3 ignored");

        // R8: lookup in the cycle of a target write uses old contents
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'hAAAA_AAAA;
        lk_req = 1'b1; lk_addr = 48'h100;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
        check("R8 old value hit", {31'd0, rsp_hit}, 32'd1);
        check("R8 old value port", {24'd0, rsp_port}, 32'h11);
        m_lo = 32'hAAAA_AAAA;
        lookup(48'h100, "R8 new value");

        // R3: uncommit afterwards
        wr(2'd0, 32'h0000_0030);
        lookup(48'h300, "R3 uncommit");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule